// File: doc/BRIEF.md
# Multi-Precision Reciprocal Evaluator

This block computes the reciprocal of a fixed-point mantissa in [1,2). The integer bit of the operand is implicitly one, so only its 31 fraction bits are presented. The top fraction bits pick a segment of the input range. Each segment owns a short set of polynomial coefficients held in constant tables inside the block. The remaining fraction bits form the offset within that segment. The polynomial is evaluated by Horner's rule: a single multiplier and a single adder are reused over several clock cycles, with one multiply-add per polynomial degree.

A two-bit precision input chooses 8, 16, 24 or 32 result bits when a request is accepted. That choice sets the polynomial degree, the table, and the working width of the datapath. In the narrower modes, the low operand bits are never loaded and the unused fraction bits of the accumulator are forced to zero, so that logic does not toggle. The two widest modes share one table. A request is made with a one-cycle `start`. Completion is a one-cycle `done` pulse, and the result stays on the output until the next completion.

Top module: `recip_eval`

## Requirements
- R1: While reset is low and after it is released with no request, `done` is 0 and `result` is 0.
- R2: The precision code selects N result bits: 0 gives 8, 1 gives 16, 2 gives 24 and 3 gives 32. The result approximates floor(2^N / x), where x = 1 + frac/2^31, and stays within ±2 of that value. All result bits above bit N are zero.
- R3: The polynomial degree is 1 for code 0, 2 for codes 1 and 2, and 3 for code 3. `done` rises after the (degree+1)-th rising clock edge that follows the edge accepting `start`.
- R4: `done` is high for exactly one cycle per accepted request.
- R5: `result` changes only in a cycle where `done` is high, and holds between completions while the other inputs move.
- R6: A `start` seen while a request is in progress is ignored. The running request finishes with its own operand and precision, and no extra `done` follows.
- R7: Segments are chosen by the top 5, 6, 9 and 9 fraction bits for codes 0, 1, 2 and 3. When every fraction bit below the segment field is zero, the result equals floor(2^N / x) exactly. This includes x = 1, which gives 2^N.
- R8: For codes 0, 1 and 2, fraction bits below bit 27−N (bits 18:0, 10:0 and 2:0) do not affect the result, and the operand register bits that hold them keep their previous contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request pulse, taken only when idle |
| prec | input | 2 | Precision code: 0=8, 1=16, 2=24, 3=32 bits |
| x_frac | input | 31 | Fraction bits of the operand (integer bit implied 1) |
| done | output | 1 | One-cycle completion pulse |
| result | output | 33 | floor(2^N/x) approximation, low N+1 bits used |

## Verification
Some behaviour is checked by the assertions on every cycle. These cover the single-cycle `done` pulse, a result that changes only with `done`, the absence of a new request start while busy, the INIT-to-STEP ordering, the zero result bits above the precision, and the held low operand bits in the narrow modes. Other behaviour can only be shown by the bench's scenarios, because it needs an independent reference. That includes numeric accuracy against floor(2^N/x), exactness at segment starts, per-mode latency, invariance to the ignored low operand bits, and the outcome of a start that arrives while a request is running.

// File: rtl/recip_pkg.sv
// Package: shared constants, precision encoding and the compile-time
// coefficient generator for the reciprocal evaluator.
// Assumes coefficients are left-endpoint Taylor terms of 1/a per segment.
package recip_pkg;

    localparam int XF    = 31;        // operand fraction bits
    localparam int CF    = 36;        // coefficient / accumulator fraction bits
    localparam int CW    = CF + 2;    // signed coefficient width
    localparam int GUARD = 4;         // guard bits beyond result precision
    localparam int RW    = 33;        // result width (holds 2^32)
    localparam int NCOEF = 4;         // coefficient slots per segment
    localparam int NTAB  = 3;         // number of physical tables

    typedef enum logic [1:0] {
        PREC_8  = 2'd0,
        PREC_16 = 2'd1,
        PREC_24 = 2'd2,
        PREC_32 = 2'd3
    } prec_e;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_INIT = 2'd1,
        S_STEP = 2'd2
    } seq_state_e;

    // Result bits for a precision code.
    function automatic int prec_bits(prec_e m);
        return 8 * (int'(m) + 1);
    endfunction

    // Polynomial degree for a precision code.
    function automatic int prec_deg(prec_e m);
        case (m)
            PREC_8:  return 1;
            PREC_32: return 3;
            default: return 2;
        endcase
    endfunction

    // Working fraction width kept in the datapath.
    function automatic int prec_wf(prec_e m);
        int b;
        b = prec_bits(m) + GUARD;
        return (b > CF) ? CF : b;
    endfunction

    // Table used by a precision code (the two widest share one).
    function automatic int prec_tab(prec_e m);
        case (m)
            PREC_8:  return 0;
            PREC_16: return 1;
            default: return 2;
        endcase
    endfunction

    // Segment index bits of a table.
    function automatic int tab_kbits(int t);
        case (t)
            0:       return 5;
            1:       return 6;
            default: return 9;
        endcase
    endfunction

    // Highest coefficient stored in a table.
    function automatic int tab_deg(int t);
        return t + 1;
    endfunction

    function automatic int prec_kbits(prec_e m);
        return tab_kbits(prec_tab(m));
    endfunction

    // Term n of 1/(a+h) at a = 1 + seg/2^kb: (-1)^n / a^(n+1), CF fraction bits.
    function automatic logic signed [CW-1:0] taylor_coef(int kb, int seg, int n);
        longint p;
        p = longint'(1) << CF;
        for (int i = 0; i <= n; i++) begin
            p = (p <<< kb) / ((longint'(1) << kb) + longint'(seg));
        end
        if ((n % 2) == 1) p = -p;
        return p[CW-1:0];
    endfunction

endpackage

// File: rtl/recip_coef_rom.sv
// Constant coefficient table: 2^KB segments, DEG+1 live terms each.
// Entries are computed at elaboration; unused slots read zero.
module recip_coef_rom
    import recip_pkg::*;
#(
    parameter int KB  = 5,
    parameter int DEG = 1
) (
    input  logic [KB-1:0]        seg_i,
    input  logic [1:0]           idx_i,
    output logic signed [CW-1:0] coef_o
);
    localparam int NSEG = 1 << KB;

    logic signed [CW-1:0] tbl [NSEG][NCOEF];

    // Fill every segment/term slot from the generator function.
    for (genvar j = 0; j < NSEG; j++) begin : g_seg
        for (genvar n = 0; n < NCOEF; n++) begin : g_term
            if (n <= DEG) begin : g_live
                assign tbl[j][n] = taylor_coef(KB, j, n);
            end else begin : g_zero
                assign tbl[j][n] = '0;
            end
        end
    end

    // Read port.
    assign coef_o = tbl[seg_i][idx_i];

endmodule

// File: rtl/recip_horner_step.sv
// One Horner step: sum = trunc(acc * h) + coef, then masked to the working
// width. Assumes |acc| <= 1 and h < 1 so the product fits CW bits after scaling.
module recip_horner_step
    import recip_pkg::*;
(
    input  logic signed [CW-1:0] acc_i,
    input  logic [XF-1:0]        h_i,
    input  logic signed [CW-1:0] coef_i,
    input  logic [CW-1:0]        keep_i,
    output logic signed [CW-1:0] sum_o
);
    logic signed [CW+XF:0] prod;
    logic signed [CW-1:0]  scaled;
    logic signed [CW-1:0]  sum;

    // Shared multiplier, rescaled back to CF fraction bits.
    assign prod   = acc_i * $signed({1'b0, h_i});
    assign scaled = CW'(prod >>> XF);
    // Shared adder followed by working-width truncation.
    assign sum    = scaled + coef_i;
    assign sum_o  = $signed(sum & keep_i);

endmodule

// File: rtl/recip_seq_ctrl.sv
// Sequencer: accepts a request when idle, loads the top coefficient, then
// issues one Horner step per degree and pulses done after the last one.
module recip_seq_ctrl
    import recip_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic [1:0] deg_i,
    output logic       accept_o,
    output logic       init_o,
    output logic       step_o,
    output logic       last_o,
    output logic [1:0] cidx_o,
    output logic       done_o
);
    seq_state_e state;
    logic [1:0] cnt;
    logic       done_q;

    // Decode of the current state.
    assign accept_o = start_i && (state == S_IDLE);
    assign init_o   = (state == S_INIT);
    assign step_o   = (state == S_STEP);
    assign last_o   = step_o && (cnt == 2'd0);
    assign cidx_o   = cnt;
    assign done_o   = done_q;

    // State, term counter and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            cnt    <= 2'd0;
            done_q <= 1'b0;
        end else begin
            done_q <= last_o;
            case (state)
                S_IDLE: if (start_i) begin
                    state <= S_INIT;
                    cnt   <= deg_i;
                end
                S_INIT: begin
                    state <= S_STEP;
                    cnt   <= cnt - 2'd1;
                end
                S_STEP: if (cnt == 2'd0) state <= S_IDLE;
                        else             cnt   <= cnt - 2'd1;
                default: state <= S_IDLE;
            endcase
        end
    end

    // R4: completion is a single-cycle pulse.
    a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);
    // R6: a start while busy never begins a new request.
    a_r6_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_IDLE) && start_i |=> (state != S_INIT));
    // R3: loading the top term is always followed by a step.
    a_r3_init_then_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_INIT) |=> (state == S_STEP));
    // R3: a request always has at least one step to run.
    a_r3_init_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_INIT) |-> (cnt != 2'd0));

endmodule

// File: rtl/recip_eval.sv
// Top: multi-precision reciprocal by piecewise polynomial and Horner steps.
// Latches precision, segment and offset on accept; narrow modes load only the
// high offset bits and zero the unused accumulator fraction bits.
// Assumes the operand integer bit is 1 (x in [1,2)).
module recip_eval
    import recip_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [1:0]    prec,
    input  logic [XF-1:0] x_frac,
    output logic          done,
    output logic [RW-1:0] result
);
    prec_e                prec_in;
    prec_e                mode_q;
    logic                 accept, init_en, step_en, last_step;
    logic [1:0]           cidx;
    logic [XF-1:0]        h_q, h_load, h_new, h_keep;
    logic [CW-1:0]        acc_keep;
    logic signed [CW-1:0] acc_q, coef_sel, step_sum;
    logic signed [CW-1:0] coefs [NTAB];
    logic [RW-1:0]        res_q;
    int                   wf_in, k_in, wf_q, sh_q;

    assign prec_in = prec_e'(prec);
    assign result  = res_q;

    recip_seq_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start),
        .deg_i    (2'(prec_deg(prec_in))),
        .accept_o (accept),
        .init_o   (init_en),
        .step_o   (step_en),
        .last_o   (last_step),
        .cidx_o   (cidx),
        .done_o   (done)
    );

    // Per-mode widths for the incoming request and the running one.
    always_comb begin
        wf_in = prec_wf(prec_in);
        k_in  = prec_kbits(prec_in);
        wf_q  = prec_wf(mode_q);
        sh_q  = CF - prec_bits(mode_q);
    end

    // Offset bit enables/values and working-width masks.
    always_comb begin
        for (int b = 0; b < XF; b++) begin
            h_load[b] = accept && (b >= XF - wf_in);
            h_new[b]  = (b < XF - k_in) ? x_frac[b] : 1'b0;
            h_keep[b] = (b >= XF - wf_q);
        end
        for (int b = 0; b < CW; b++) begin
            acc_keep[b] = (b >= CF - wf_q);
        end
    end

    // Precision register, captured on accept.
    always_ff @(posedge clk) begin
        if (!rst_n)      mode_q <= PREC_8;
        else if (accept) mode_q <= prec_in;
    end

    // Offset register: bits below the working width keep their contents.
    always_ff @(posedge clk) begin
        if (!rst_n) h_q <= '0;
        else begin
            for (int b = 0; b < XF; b++) begin
                if (h_load[b]) h_q[b] <= h_new[b];
            end
        end
    end

    // One table per segment resolution; only the selected table's address moves.
    for (genvar t = 0; t < NTAB; t++) begin : g_tab
        localparam int KB = tab_kbits(t);
        logic [KB-1:0] seg_r;

        // Segment address register for this table.
        always_ff @(posedge clk) begin
            if (!rst_n) seg_r <= '0;
            else if (accept && (prec_tab(prec_in) == t)) seg_r <= x_frac[XF-1 -: KB];
        end

        recip_coef_rom #(.KB(KB), .DEG(tab_deg(t))) u_rom (
            .seg_i  (seg_r),
            .idx_i  (cidx),
            .coef_o (coefs[t])
        );
    end

    // Coefficient steering by the running precision.
    always_comb begin
        case (mode_q)
            PREC_8:  coef_sel = coefs[0];
            PREC_16: coef_sel = coefs[1];
            default: coef_sel = coefs[2];
        endcase
    end

    recip_horner_step u_step (
        .acc_i  (acc_q),
        .h_i    (h_q & h_keep),
        .coef_i (coef_sel),
        .keep_i (acc_keep),
        .sum_o  (step_sum)
    );

    // Accumulator: top term on init, Horner update on each step.
    always_ff @(posedge clk) begin
        if (!rst_n)       acc_q <= '0;
        else if (init_en) acc_q <= $signed(coef_sel & acc_keep);
        else if (step_en) acc_q <= step_sum;
    end

    // Result register: rescaled final sum, written with the last step.
    always_ff @(posedge clk) begin
        if (!rst_n)         res_q <= '0;
        else if (last_step) res_q <= RW'(step_sum >>> sh_q);
    end

    // R8: narrow modes never load the lowest offset bit.
    a_r8_low_operand_held: assert property (@(posedge clk) disable iff (!rst_n)
        accept && (prec_in != PREC_32) |=> $stable(h_q[0]));
    // R2: no result bit above bit N at completion.
    a_r2_result_range: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((result >> (prec_bits(mode_q) + 1)) == '0));
    // R5: the result moves only together with done.
    a_r5_result_held: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result) |-> done);

endmodule

// File: tb/sim_recip_eval.sv
`timescale 1ns/1ps
module sim_recip_eval;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  prec = 2'd0;
    logic [30:0] x_frac = '0;
    logic        done;
    logic [32:0] result;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    recip_eval u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .prec(prec),
        .x_frac(x_frac), .done(done), .result(result)
    );

    function automatic int bits_of(logic [1:0] m); return 8 * (int'(m) + 1); endfunction
    function automatic int deg_of(logic [1:0] m);
        return (m == 2'd0) ? 1 : (m == 2'd3) ? 3 : 2;
    endfunction
    function automatic int k_of(logic [1:0] m);
        return (m == 2'd0) ? 5 : (m == 2'd1) ? 6 : 9;
    endfunction
    function automatic longint ref_recip(logic [1:0] m, logic [30:0] f);
        longint unsigned num, den;
        num = 64'h1 << (bits_of(m) + 31);
        den = 64'({1'b1, f});
        return longint'(num / den);
    endfunction

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // Issue one request and measure edges from accept to done.
    task automatic run_op(input logic [1:0] m, input logic [30:0] f,
                          output logic [32:0] r, output int lat);
        @(negedge clk);
        start = 1'b1; prec = m; x_frac = f;
        @(negedge clk);
        start = 1'b0;
        lat = 99;
        for (int i = 1; i <= 12; i++) begin
            @(posedge clk); #1;
            if (done) begin lat = i; break; end
        end
        r = result;
    endtask

    task automatic t_reset();
        check(done == 1'b0, "R1", "done in reset", done, 0);
        check(result == '0, "R1", "result in reset", result, 0);
        @(negedge clk); rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(done == 1'b0, "R1", "done after reset", done, 0);
        check(result == '0, "R1", "result after reset", result, 0);
    endtask

    task automatic t_accuracy(input logic [1:0] m);
        logic [32:0] r; int lat; longint e; logic [30:0] f;
        for (int i = 0; i < 20; i++) begin
            case (i)
                0: f = 31'h7FFF_FFFF;
                1: f = 31'h4000_0000;
                2: f = 31'h2AAA_AAAA;
                3: f = 31'h0000_0001;
                default: f = 31'((i * 7 + 1) * 32'h9E37_79B1);
            endcase
            run_op(m, f, r, lat);
            e = ref_recip(m, f);
            check((longint'(r) - e <= 2) && (e - longint'(r) <= 2), "R2", "accuracy", r, e);
            check(lat == deg_of(m) + 1, "R3", "latency", lat, deg_of(m) + 1);
        end
    endtask

    task automatic t_segment_starts(input logic [1:0] m);
        logic [32:0] r; int lat; logic [30:0] f; longint e;
        for (int j = 0; j < 6; j++) begin
            f = 31'(((j * 13) % (1 << k_of(m))) << (31 - k_of(m)));
            run_op(m, f, r, lat);
            e = ref_recip(m, f);
            check(longint'(r) == e, "R7", "segment start exact", r, e);
        end
    endtask

    task automatic t_pulse_hold();
        logic [32:0] r; int lat;
        run_op(2'd2, 31'h1234_5678, r, lat);
        @(posedge clk); #1;
        check(done == 1'b0, "R4", "done width", done, 0);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); x_frac = 31'(i * 32'h1357_9BDF); prec = 2'(i);
            @(posedge clk); #1;
            check(result == r, "R5", "result held", result, r);
            check(done == 1'b0, "R4", "no spurious done", done, 0);
        end
    endtask

    task automatic t_busy_start();
        logic [32:0] ra; int lat; int seen;
        run_op(2'd3, 31'h2468_ACE0, ra, lat);
        @(negedge clk); start = 1'b1; prec = 2'd3; x_frac = 31'h2468_ACE0;
        @(negedge clk); prec = 2'd0; x_frac = 31'h7000_0000;
        @(negedge clk); start = 1'b0;
        seen = 0;
        for (int i = 0; i < 10; i++) begin
            @(posedge clk); #1;
            if (done) begin
                seen++;
                check(result == ra, "R6", "busy start ignored", result, ra);
            end
        end
        check(seen == 1, "R6", "single done", seen, 1);
    endtask

    task automatic t_low_bits();
        logic [32:0] r1, r2; int lat; logic [30:0] base, flip;
        base = 31'h5A5A_5A5A;
        for (int mi = 0; mi < 3; mi++) begin
            flip = 31'((64'h1 << (27 - bits_of(2'(mi)))) - 1);
            run_op(2'(mi), base, r1, lat);
            run_op(2'(mi), base ^ flip, r2, lat);
            check(r1 == r2, "R8", "low bits ignored", r2, r1);
        end
    endtask

    initial begin
        t_reset();
        for (int m = 0; m < 4; m++) t_accuracy(2'(m));
        for (int m = 0; m < 4; m++) t_segment_starts(2'(m));
        t_pulse_hold();
        t_busy_start();
        t_low_bits();
        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL R3 watchdog: actual 0 expected 1");
            summary();
            $finish;
        end
    end
endmodule